// File: doc/BRIEF.md
# Display Panel Line and Frame Timing Generator

This block produces the sweep timing for a display panel. It drives a shift clock, a line-start pulse, a frame-start marker and a data-valid strobe. It also exposes the current pixel column and line index, which a separate pixel data path uses to place data on the panel bus. The same four timing pins serve two panel families. For an active-matrix panel they act as a continuous pixel clock, horizontal sync, vertical sync and output enable. For a passive panel they act as a gated shift clock, line pulse, frame marker and data strobe.

The generator advances only on cycles where the pixel clock enable is high. Each line consists of four parts in this order:
- an active data phase;
- a front wait;
- the line pulse;
- a back wait.

The wait and pulse lengths are given in time units whose length depends on the passive data bus width. In passive mode a programmable number of blank lines follows the visible lines of each frame. All programming inputs are captured together at each frame start, so changing them during a frame does not affect the lines already in progress.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, and until the first cycle with `pix_en` high, every timing output is 0 and `pix_x`/`line_y` are 0. The first enabled cycle starts line 0 of a frame in its active phase, column 0, with the shift clock in its low half.
- R2: Each line runs through its phases in this order. First is the active phase, lasting `xmax` shift periods. Next is the front wait, lasting `hwait_front`+1 units. Then comes the line pulse, lasting `hwidth`+1 units. Last is the back wait, lasting `hwait_back`+2 units. The line pulse is active only during the pulse phase.
- R3: One time unit is one shift period in active-matrix mode (`tft_mode`=1), in passive colour mode (`mono_mode`=0), and in passive mono mode with `bus_width`=0 (1-bit). In passive mono mode, `bus_width` codes 1, 2 and 3 (2-, 4- and 8-bit bus) give 1, 2 and 4 shift periods per unit.
- R4: A shift period is two enabled cycles: raw clock low, then high. The `shift_clk` output is the raw clock XOR `pol_clk` XOR `tft_mode`. In active-matrix mode the raw clock runs on every line phase. In passive mode it runs only during the active phase, and otherwise rests low.
- R5: `pol_line`, `pol_frame` and `pol_oe` set to 1 make `line_pulse`, `frame_mark` and `out_en` active-low.
- R6: A frame is `ymax` lines in active-matrix mode and `ymax`+`frame_wait` lines in passive mode. `frame_mark` is active during the line pulse of the last line of the frame.
- R7: `out_en` is active during the active phase of lines 0 to `ymax`-1 only. During the active phase `pix_x` counts 0 to `xmax`-1; otherwise it is 0. `line_y` gives the current line index.
- R8: Programming inputs, polarities included, are sampled on the first enabled cycle after reset and on the enabled cycle that wraps to line 0. Changes between those cycles have no effect on the outputs.
- R9: While `pix_en` is low, every output and all internal timing state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable; timing advances one half shift period per enabled cycle |
| tft_mode | input | 1 | 1 = active-matrix panel, 0 = passive panel |
| mono_mode | input | 1 | Passive mono panel (1) or passive colour panel (0) |
| bus_width | input | 2 | Passive mono bus width code: 0 = 1, 1 = 2, 2 = 4, 3 = 8 bits |
| hwidth | input | HW | Line pulse width field (units, plus 1) |
| hwait_front | input | HW | Wait before the line pulse (units, plus 1) |
| hwait_back | input | HW | Wait after the line pulse (units, plus 2) |
| xmax | input | XW | Active shift periods per line (at least 1) |
| ymax | input | YW | Visible lines per frame (at least 1) |
| frame_wait | input | FW | Passive blank lines after the visible lines |
| pol_frame | input | 1 | Frame marker active-low when 1 |
| pol_line | input | 1 | Line pulse active-low when 1 |
| pol_clk | input | 1 | Shift clock inversion |
| pol_oe | input | 1 | Output enable active-low when 1 |
| shift_clk | output | 1 | Shift clock |
| line_pulse | output | 1 | Line pulse / horizontal sync |
| frame_mark | output | 1 | Frame marker / vertical sync |
| out_en | output | 1 | Data valid strobe |
| pix_x | output | XW | Pixel column within the active phase |
| line_y | output | max(YW,FW)+1 | Line index within the frame |

## Verification
The embedded assertions check the following on every cycle:
- the phase counter never passes the length of its phase;
- the line index never passes the last line of the frame;
- the captured configuration changes only on a load;
- timing state freezes when the enable is low;
- the data strobe is active only in the active phase;
- in passive mode the shift clock rests while outside that phase.

Only the bench's scenarios can show the following:
- the exact phase lengths for each unit multiplier;
- the frame length with and without blank lines;
- placement of the frame marker on the last line's pulse;
- polarity handling;
- that a mid-frame change to the programming inputs takes effect exactly at the next frame.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  typedef enum logic [1:0] {
    PH_ACT   = 2'd0,
    PH_FRONT = 2'd1,
    PH_PULSE = 2'd2,
    PH_BACK  = 2'd3
  } hphase_e;

  // log2 of shift periods per time unit
  function automatic logic [1:0] unit_shift(input logic tft,
                                            input logic mono,
                                            input logic [1:0] bw);
    logic [1:0] s;
    if (tft || !mono) begin
      s = 2'd0;
    end else begin
      unique case (bw)
        2'd0, 2'd1: s = 2'd0;
        2'd2:       s = 2'd1;
        default:    s = 2'd2;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/lcd_cfg_reg.sv
module lcd_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R8: captured programming only moves on a load
  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcd_sync_pkg::*;
#(
  parameter int XW = 10,
  parameter int LW = 11,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [XW-1:0] xmax,
  input  logic [LW-1:0] len_front,
  input  logic [LW-1:0] len_pulse,
  input  logic [LW-1:0] len_back,
  output logic          ph,
  output hphase_e       phase,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cur_len,
  output logic          line_end
);

  logic          ph_d;
  hphase_e       phase_d;
  logic [CW-1:0] cnt_d;
  logic          tick;
  logic          last_p;

  always_comb begin
    unique case (phase)
      PH_ACT:   cur_len = CW'(xmax);
      PH_FRONT: cur_len = CW'(len_front);
      PH_PULSE: cur_len = CW'(len_pulse);
      default:  cur_len = CW'(len_back);
    endcase
  end

  assign tick     = en & ph;
  assign last_p   = (cnt == cur_len - CW'(1));
  assign line_end = tick & (phase == PH_BACK) & last_p;

  always_comb begin
    ph_d    = en ? ~ph : ph;
    cnt_d   = cnt;
    phase_d = phase;
    if (tick) begin
      if (last_p) begin
        cnt_d = '0;
        unique case (phase)
          PH_ACT:   phase_d = PH_FRONT;
          PH_FRONT: phase_d = PH_PULSE;
          PH_PULSE: phase_d = PH_BACK;
          default:  phase_d = PH_ACT;
        endcase
      end else begin
        cnt_d = cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= 1'b0;
      phase <= PH_ACT;
      cnt   <= '0;
    end else begin
      ph    <= ph_d;
      phase <= phase_d;
      cnt   <= cnt_d;
    end
  end

  // R9: no enable, no movement
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(ph) && $stable(cnt) && $stable(phase)));

endmodule

// File: rtl/lcd_frame_counter.sv
module lcd_frame_counter #(
  parameter int NW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          line_end,
  input  logic [NW-1:0] last_line,
  output logic          running,
  output logic          load,
  output logic [NW-1:0] line_y
);

  logic          running_d;
  logic [NW-1:0] line_d;
  logic          wrap;

  assign wrap = line_end & (line_y == last_line);
  assign load = (pix_en & ~running) | wrap;

  always_comb begin
    running_d = running | pix_en;
    line_d    = line_y;
    if (line_end) line_d = wrap ? '0 : line_y + NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      line_y  <= '0;
    end else begin
      running <= running_d;
      line_y  <= line_d;
    end
  end

  // R6: line index stays inside the frame
  a_r6_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (line_y <= last_line));

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int HW = 8,
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int FW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pix_en,
  input  logic                          tft_mode,
  input  logic                          mono_mode,
  input  logic [1:0]                    bus_width,
  input  logic [HW-1:0]                 hwidth,
  input  logic [HW-1:0]                 hwait_front,
  input  logic [HW-1:0]                 hwait_back,
  input  logic [XW-1:0]                 xmax,
  input  logic [YW-1:0]                 ymax,
  input  logic [FW-1:0]                 frame_wait,
  input  logic                          pol_frame,
  input  logic                          pol_line,
  input  logic                          pol_clk,
  input  logic                          pol_oe,
  output logic                          shift_clk,
  output logic                          line_pulse,
  output logic                          frame_mark,
  output logic                          out_en,
  output logic [XW-1:0]                 pix_x,
  output logic [((YW>FW)?YW:FW):0]      line_y
);

  localparam int LW   = HW + 3;
  localparam int CW   = (XW > LW) ? XW : LW;
  localparam int NW   = ((YW > FW) ? YW : FW) + 1;
  localparam int CFGW = 4 + 3*HW + XW + YW + FW + 4;

  logic          c_tft, c_mono;
  logic [1:0]    c_bw;
  logic [HW-1:0] c_hw, c_hwf, c_hwb;
  logic [XW-1:0] c_x;
  logic [YW-1:0] c_y;
  logic [FW-1:0] c_fw;
  logic          c_pf, c_pl, c_pc, c_po;
  logic [CFGW-1:0] cfg_q;

  logic          load, running, line_end, ph;
  hphase_e       phase;
  logic [CW-1:0] cnt, cur_len;
  logic [1:0]    sh;
  logic [LW-1:0] len_front, len_pulse, len_back;
  logic [NW-1:0] last_line;
  logic          act, vis, oe_act, raw_clk;

  lcd_cfg_reg #(.W(CFGW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     ({tft_mode, mono_mode, bus_width, hwidth, hwait_front, hwait_back,
             xmax, ymax, frame_wait, pol_frame, pol_line, pol_clk, pol_oe}),
    .q     (cfg_q)
  );

  assign {c_tft, c_mono, c_bw, c_hw, c_hwf, c_hwb,
          c_x, c_y, c_fw, c_pf, c_pl, c_pc, c_po} = cfg_q;

  assign sh        = unit_shift(c_tft, c_mono, c_bw);
  assign len_front = (LW'(c_hwf) + LW'(1)) << sh;
  assign len_pulse = (LW'(c_hw)  + LW'(1)) << sh;
  assign len_back  = (LW'(c_hwb) + LW'(2)) << sh;
  assign last_line = NW'(c_y) - NW'(1) + (c_tft ? NW'(0) : NW'(c_fw));

  lcd_line_timer #(.XW(XW), .LW(LW), .CW(CW)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (pix_en & running),
    .xmax      (c_x),
    .len_front (len_front),
    .len_pulse (len_pulse),
    .len_back  (len_back),
    .ph        (ph),
    .phase     (phase),
    .cnt       (cnt),
    .cur_len   (cur_len),
    .line_end  (line_end)
  );

  lcd_frame_counter #(.NW(NW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_en    (pix_en),
    .line_end  (line_end),
    .last_line (last_line),
    .running   (running),
    .load      (load),
    .line_y    (line_y)
  );

  assign act     = (phase == PH_ACT);
  assign vis     = (line_y < NW'(c_y));
  assign oe_act  = act & vis;
  assign raw_clk = (c_tft | act) & ph;

  assign shift_clk  = raw_clk ^ c_pc ^ c_tft;
  assign line_pulse = (phase == PH_PULSE) ^ c_pl;
  assign frame_mark = ((phase == PH_PULSE) && (line_y == last_line)) ^ c_pf;
  assign out_en     = oe_act ^ c_po;
  assign pix_x      = act ? cnt[XW-1:0] : '0;

  // R2: phase counter stays below its phase length
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < cur_len));

  // R7: data strobe only while in the active phase
  a_r7_oe_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en ^ c_po) |-> (phase == PH_ACT));

  // R4: passive shift clock rests outside the active phase
  a_r4_passive_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_tft && phase != PH_ACT) |-> (shift_clk == c_pc));

endmodule

// File: tb/lcd_sync_gen_bench.sv
`timescale 1ns/1ps
module lcd_sync_gen_bench;

  localparam int HW = 8, XW = 10, YW = 10, FW = 8;
  localparam int NW = ((YW > FW) ? YW : FW) + 1;

  logic clk = 1'b0;
  logic rst_n, pix_en, tft_mode, mono_mode;
  logic [1:0] bus_width;
  logic [HW-1:0] hwidth, hwait_front, hwait_back;
  logic [XW-1:0] xmax;
  logic [YW-1:0] ymax;
  logic [FW-1:0] frame_wait;
  logic pol_frame, pol_line, pol_clk, pol_oe;
  logic shift_clk, line_pulse, frame_mark, out_en;
  logic [XW-1:0] pix_x;
  logic [NW-1:0] line_y;

  always #4 clk = ~clk;

  lcd_sync_gen #(.HW(HW), .XW(XW), .YW(YW), .FW(FW)) u_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .tft_mode(tft_mode),
    .mono_mode(mono_mode), .bus_width(bus_width), .hwidth(hwidth),
    .hwait_front(hwait_front), .hwait_back(hwait_back), .xmax(xmax),
    .ymax(ymax), .frame_wait(frame_wait), .pol_frame(pol_frame),
    .pol_line(pol_line), .pol_clk(pol_clk), .pol_oe(pol_oe),
    .shift_clk(shift_clk), .line_pulse(line_pulse), .frame_mark(frame_mark),
    .out_en(out_en), .pix_x(pix_x), .line_y(line_y)
  );

  typedef struct {
    bit sclk, lp, fm, oe;
    int x, y;
    string tag;
  } item_t;

  typedef struct {
    bit tft, mono;
    int bw, hw, w1, w2, x, y, fw;
    bit pf, pl, pc, po;
  } bcfg_t;

  item_t q[$];
  item_t last_exp;
  int checks = 0, fails = 0, stall = 0;
  bit done = 1'b0;

  task automatic cmp(string f, int a, int e, string tag);
    checks++;
    if (a != e) begin
      fails++;
      $display("FAIL %s field %s actual=%0d expected=%0d at %0t", tag, f, a, e, $time);
    end
  endtask

  // monitor: compares the state produced by each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        cmp("shift_clk",  int'(shift_clk),  int'(e.sclk), e.tag);
        cmp("line_pulse", int'(line_pulse), int'(e.lp),   e.tag);
        cmp("frame_mark", int'(frame_mark), int'(e.fm),   e.tag);
        cmp("out_en",     int'(out_en),     int'(e.oe),   e.tag);
        cmp("pix_x",      int'(pix_x),      e.x,          e.tag);
        cmp("line_y",     int'(line_y),     e.y,          e.tag);
      end
    end
  end

  task automatic apply(bcfg_t c);
    tft_mode = c.tft; mono_mode = c.mono; bus_width = 2'(c.bw);
    hwidth = HW'(c.hw); hwait_front = HW'(c.w1); hwait_back = HW'(c.w2);
    xmax = XW'(c.x); ymax = YW'(c.y); frame_wait = FW'(c.fw);
    pol_frame = c.pf; pol_line = c.pl; pol_clk = c.pc; pol_oe = c.po;
  endtask

  // R8: garbage on the programming inputs mid-frame
  task automatic scramble(bcfg_t c);
    tft_mode = ~c.tft; xmax = XW'(c.x + 3); ymax = YW'(c.y + 2);
    hwidth = HW'(c.hw + 2); pol_line = ~c.pl; pol_oe = ~c.po;
    bus_width = 2'(c.bw + 1); frame_wait = FW'(c.fw + 4);
  endtask

  task automatic step(item_t e);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      pix_en = 1'b0;
      q.push_back(last_exp); // R9: held while disabled
    end
    @(negedge clk);
    pix_en = 1'b1;
    q.push_back(e);
    last_exp = e;
  endtask

  function automatic int tmul(bcfg_t c);
    if (c.tft || !c.mono) return 1; // R3
    if (c.bw == 3) return 4;
    if (c.bw == 2) return 2;
    return 1;
  endfunction

  task automatic gen_frame(bcfg_t c, string tag, int scr);
    int last, tm, n;
    last = c.y - 1 + (c.tft ? 0 : c.fw); // R6
    tm = tmul(c);
    n = 0;
    apply(c);
    for (int ln = 0; ln <= last; ln++) begin
      for (int p = 0; p < 4; p++) begin
        int len;
        len = (p == 0) ? c.x : (p == 1) ? (c.w1 + 1) * tm :
              (p == 2) ? (c.hw + 1) * tm : (c.w2 + 2) * tm; // R2
        for (int k = 0; k < len; k++) begin
          for (int h = 0; h < 2; h++) begin
            item_t e;
            bit act;
            act = (p == 0);
            e.sclk = (((c.tft || act) ? bit'(h) : 1'b0) ^ c.pc ^ c.tft); // R4
            e.lp = (p == 2) ^ c.pl;                                     // R5
            e.fm = ((p == 2) && (ln == last)) ^ c.pf;                   // R6
            e.oe = (act && (ln < c.y)) ^ c.po;                          // R7
            e.x = act ? k : 0;
            e.y = ln;
            e.tag = tag;
            step(e);
            n++;
            if (n == scr) scramble(c);
          end
        end
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bcfg_t a, b, cc, d, e5, f6;
    item_t z;
    rst_n = 1'b0; pix_en = 1'b0;
    apply('{default: 0});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    z.sclk = 0; z.lp = 0; z.fm = 0; z.oe = 0; z.x = 0; z.y = 0; z.tag = "R1 reset";
    last_exp = z;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      pix_en = 1'b0;
      q.push_back(z);
    end

    a = '{tft:1, mono:0, bw:0, hw:1, w1:0, w2:1, x:4, y:3, fw:2,
          pf:0, pl:0, pc:0, po:0};
    gen_frame(a, "R1 R2 R4 R6 R7 tft", 0);
    gen_frame(a, "R2 R6 R8 tft repeat", 0);

    b = '{tft:1, mono:0, bw:0, hw:0, w1:1, w2:0, x:3, y:2, fw:0,
          pf:1, pl:1, pc:0, po:1};
    stall = 1;
    gen_frame(b, "R5 R8 R9 polarity stall", 0);
    stall = 2;
    gen_frame(b, "R5 R9 stall2", 0);
    stall = 0;

    cc = '{tft:0, mono:0, bw:3, hw:1, w1:2, w2:0, x:5, y:2, fw:2,
           pf:0, pl:0, pc:1, po:0};
    gen_frame(cc, "R3 R4 R6 passive colour", 0);

    d = '{tft:0, mono:1, bw:3, hw:0, w1:0, w2:0, x:2, y:2, fw:1,
          pf:0, pl:1, pc:0, po:0};
    gen_frame(d, "R3 R8 mono x4 scrambled", 7);
    gen_frame(d, "R3 R8 mono x4", 0);

    e5 = '{tft:0, mono:1, bw:2, hw:1, w1:1, w2:1, x:3, y:1, fw:1,
           pf:1, pl:0, pc:1, po:1};
    gen_frame(e5, "R3 R5 mono x2", 0);

    f6 = '{tft:0, mono:1, bw:1, hw:2, w1:0, w2:0, x:2, y:2, fw:0,
           pf:0, pl:0, pc:0, po:0};
    gen_frame(f6, "R3 mono 2bit x1", 0);

    @(negedge clk);
    pix_en = 1'b0;
    wait (q.size() == 0);
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule